// File: doc/BRIEF.md
# Crystal Oscillator Control Block

This block is the register-side controller for an on-chip crystal oscillator. Software reaches it over a zero-wait-state APB port. Through that port it sets:

- whether the oscillator is enabled;
- whether it is paused to save power;
- how long it must run before it counts as settled.

The oscillator itself is outside the block. It is represented by two signals. The output `osc_run` is a registered run request. The input `osc_tick` is a one-cycle pulse for each crystal period. All logic runs on the single system clock.

The enable and pause settings accept only specific key values, which guards against stray writes. Any other value falls back to the running state and raises a sticky error flag in the status word. Writing one to that bit clears it.

A startup timer counts crystal ticks once the oscillator runs. It raises a stable flag after the programmed delay, which is counted in units of 256 ticks and can be scaled by four. An 8-bit down counter gives software short pauses measured in crystal ticks.

Top module: `xo_ctrl_top`

## Requirements
- R1: After reset the registers read as follows, and `osc_run` is 0:
  - control (offset 0x00) reads 0x00D1EAA0;
  - status (0x04) reads 0;
  - pause (0x08) reads 0x77616B65;
  - startup (0x0C) reads 0x000000C4;
  - counter (0x1C) reads 0.
- R2: The control enable field is bits 23:12. Writing 0xD1E disables the oscillator and writing 0xFAB enables it.
  - The field reads back 0xD1E or 0xFAB to match the setting.
  - Status bit 12 shows the setting.
  - `osc_run` follows the setting on the second clock edge after the write.
- R3: Writing any other enable code enables the oscillator, which then reads back 0xFAB, and sets status bit 24.
- R4: Control bits 11:0 always read 0xAA0, and status bits 1:0 always read 0.
  - Writing 0xAA0 to 0xAA3 leaves the error flag alone.
  - Writing any other value sets status bit 24.
- R5: The pause register is 32 bits. 0x636F6D61 pauses the oscillator and 0x77616B65 wakes it, and it reads back whichever of the two is in effect.
  - Any other value selects wake and sets status bit 24.
  - `osc_run` is 1 only when the oscillator is enabled and not paused.
- R6: Status bit 24 stays set until a status write with bit 24 at 1. A status write with bit 24 at 0 leaves it set.
- R7: The startup register holds a 14-bit delay in bits 13:0 and a times-four flag in bit 20. All other bits read 0.
- R8: Status bit 31 (stable) rises once `osc_run` has been 1 for delay×256 ticks, or delay×1024 ticks with the flag set, and not one tick sooner.
- R9: When `osc_run` drops, the stable flag clears and the tick count restarts from zero. Re-enabling or waking needs the full delay again.
- R10: The counter register (offset 0x1C, bits 7:0) loads on a write and reads back its current value.
  - It decrements by one per tick only while stable, and stops at zero.
  - A write in the same cycle as a tick loads the written value.
- R11: PREADY reads 1 and PSLVERR reads 0 on every access. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| osc_tick | input | 1 | One pulse per crystal period |
| osc_run | output | 1 | Registered oscillator run request |

## Verification
Two functions can act on the pause counter in the same clock cycle: a software load, and a crystal tick that would decrement the counter. The bench provokes this by holding `osc_tick` high through the whole APB write to the counter while the oscillator is stable. It then reads back the counter and expects exactly the written value, with no decrement. The startup threshold is judged at its exact edge: the status is read after one tick fewer than the delay needs and again after the final tick, for both the plain and the times-four scaling.

// File: rtl/xo_ctrl_pkg.sv
// Shared constants for the crystal oscillator controller: register
// offsets, key codes and status bit positions.
package xo_ctrl_pkg;

    localparam int unsigned DATA_W = 32;

    // Register word offsets (byte addresses)
    localparam logic [7:0] OFF_CTRL    = 8'h00;
    localparam logic [7:0] OFF_STATUS  = 8'h04;
    localparam logic [7:0] OFF_PAUSE   = 8'h08;
    localparam logic [7:0] OFF_STARTUP = 8'h0C;
    localparam logic [7:0] OFF_COUNT   = 8'h1C;

    // Key codes
    localparam logic [11:0] KEY_OFF    = 12'hD1E;
    localparam logic [11:0] KEY_ON     = 12'hFAB;
    localparam logic [11:0] RANGE_BASE = 12'hAA0;
    localparam logic [31:0] KEY_PAUSE  = 32'h636F6D61;
    localparam logic [31:0] KEY_WAKE   = 32'h77616B65;

    // Bit positions
    localparam int unsigned ST_STABLE_BIT = 31;
    localparam int unsigned ST_BAD_BIT    = 24;
    localparam int unsigned ST_EN_BIT     = 12;
    localparam int unsigned SU_X4_BIT     = 20;
    localparam int unsigned EN_LSB        = 12;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STATUS,
        SEL_PAUSE,
        SEL_STARTUP,
        SEL_COUNT
    } reg_sel_e;

endpackage

// File: rtl/xo_apb_regs.sv
// APB register file of the oscillator controller.
// Decodes zero-wait accesses, checks key codes, keeps the sticky error flag
// and produces the registered run request.
// Assumes one access per APB transfer (psel and penable both high).
module xo_apb_regs
    import xo_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DELAY_W   = 14,
    parameter int unsigned CNT_W     = 8,
    parameter logic [DELAY_W-1:0] DELAY_RST = DELAY_W'(8'hC4)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [DATA_W-1:0]   pwdata,
    output logic [DATA_W-1:0]   prdata,
    input  logic                stable_i,
    input  logic [CNT_W-1:0]    count_i,
    output logic                osc_run,
    output logic [DELAY_W-1:0]  delay_o,
    output logic                x4_o,
    output logic                bad_o,
    output logic                cnt_wr_o,
    output logic [CNT_W-1:0]    cnt_wdata_o
);

    reg_sel_e           sel;
    logic               wr_en;
    logic               rd_en;
    logic               enabled_q;
    logic               paused_q;
    logic               bad_q;
    logic [DELAY_W-1:0] delay_q;
    logic               x4_q;
    logic [11:0]        en_code;
    logic [11:0]        range_code;
    logic               ctrl_bad;
    logic               pause_bad;
    logic               set_bad;
    logic               clr_bad;
    logic [DATA_W-1:0]  rd_mux;

    assign wr_en = psel && penable && pwrite;
    assign rd_en = psel && penable && !pwrite;

    // Address decode of the selected register
    always_comb begin
        if (paddr == ADDR_W'(OFF_CTRL))         sel = SEL_CTRL;
        else if (paddr == ADDR_W'(OFF_STATUS))  sel = SEL_STATUS;
        else if (paddr == ADDR_W'(OFF_PAUSE))   sel = SEL_PAUSE;
        else if (paddr == ADDR_W'(OFF_STARTUP)) sel = SEL_STARTUP;
        else if (paddr == ADDR_W'(OFF_COUNT))   sel = SEL_COUNT;
        else                                    sel = SEL_NONE;
    end

    // Key code classification of the write data
    always_comb begin
        en_code    = pwdata[EN_LSB +: 12];
        range_code = pwdata[11:0];
        ctrl_bad   = ((en_code != KEY_OFF) && (en_code != KEY_ON))
                     || (range_code[11:2] != RANGE_BASE[11:2]);
        pause_bad  = (pwdata != KEY_PAUSE) && (pwdata != KEY_WAKE);
        set_bad    = wr_en && (((sel == SEL_CTRL) && ctrl_bad)
                               || ((sel == SEL_PAUSE) && pause_bad));
        clr_bad    = wr_en && (sel == SEL_STATUS) && pwdata[ST_BAD_BIT];
    end

    // Enable, pause and startup settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled_q <= 1'b0;
            paused_q  <= 1'b0;
            delay_q   <= DELAY_RST;
            x4_q      <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL:    enabled_q <= (en_code != KEY_OFF);
                SEL_PAUSE:   paused_q  <= (pwdata == KEY_PAUSE);
                SEL_STARTUP: begin
                    delay_q <= pwdata[DELAY_W-1:0];
                    x4_q    <= pwdata[SU_X4_BIT];
                end
                default: ;
            endcase
        end
    end

    // Sticky error flag: set on a rejected code, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n)       bad_q <= 1'b0;
        else if (set_bad) bad_q <= 1'b1;
        else if (clr_bad) bad_q <= 1'b0;
    end

    // Registered run request towards the oscillator
    always_ff @(posedge clk) begin
        if (!rst_n) osc_run <= 1'b0;
        else        osc_run <= enabled_q && !paused_q;
    end

    // Read data multiplexer
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_CTRL: begin
                rd_mux[EN_LSB +: 12] = enabled_q ? KEY_ON : KEY_OFF;
                rd_mux[11:0]         = RANGE_BASE;
            end
            SEL_STATUS: begin
                rd_mux[ST_STABLE_BIT] = stable_i;
                rd_mux[ST_BAD_BIT]    = bad_q;
                rd_mux[ST_EN_BIT]     = enabled_q;
            end
            SEL_PAUSE:   rd_mux = paused_q ? KEY_PAUSE : KEY_WAKE;
            SEL_STARTUP: begin
                rd_mux[DELAY_W-1:0] = delay_q;
                rd_mux[SU_X4_BIT]   = x4_q;
            end
            SEL_COUNT:   rd_mux[CNT_W-1:0] = count_i;
            default: ;
        endcase
    end

    assign prdata      = rd_en ? rd_mux : '0;
    assign delay_o     = delay_q;
    assign x4_o        = x4_q;
    assign bad_o       = bad_q;
    assign cnt_wr_o    = wr_en && (sel == SEL_COUNT);
    assign cnt_wdata_o = pwdata[CNT_W-1:0];

endmodule

// File: rtl/xo_startup_timer.sv
// Startup timer: counts crystal ticks while the run request is high and
// raises the stable flag after delay << SCALE_SHIFT ticks (plus X4_SHIFT
// more shift bits when scaling is on). Dropping the run request clears the
// flag and the count at once.
module xo_startup_timer #(
    parameter int unsigned DELAY_W     = 14,
    parameter int unsigned SCALE_SHIFT = 8,
    parameter int unsigned X4_SHIFT    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               tick_i,
    input  logic [DELAY_W-1:0] delay_i,
    input  logic               x4_i,
    output logic               stable_o
);

    localparam int unsigned TGT_W = DELAY_W + SCALE_SHIFT + X4_SHIFT;

    logic [TGT_W-1:0] target;
    logic [TGT_W-1:0] ticks_q;

    // Tick threshold from the programmed delay and scaling
    always_comb begin
        if (x4_i) target = TGT_W'(delay_i) << (SCALE_SHIFT + X4_SHIFT);
        else      target = TGT_W'(delay_i) << SCALE_SHIFT;
    end

    // Tick accumulation and stable flag
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            ticks_q  <= '0;
            stable_o <= 1'b0;
        end else if (ticks_q >= target) begin
            stable_o <= 1'b1;
        end else if (tick_i) begin
            ticks_q <= ticks_q + 1'b1;
        end
    end

endmodule

// File: rtl/xo_pause_counter.sv
// Software pause counter: loads on a register write and counts down one
// per crystal tick while the oscillator is stable, halting at zero.
// A load in the same cycle as a tick takes priority.
module xo_pause_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             tick_i,
    input  logic             stable_i,
    output logic [CNT_W-1:0] count_o
);

    // Load or decrement the counter
    always_ff @(posedge clk) begin
        if (!rst_n)                                   count_o <= '0;
        else if (wr_i)                                count_o <= wdata_i;
        else if (tick_i && stable_i && count_o != '0) count_o <= count_o - 1'b1;
    end

endmodule

// File: rtl/xo_ctrl_top.sv
// Top of the crystal oscillator controller. It joins the APB register file,
// the startup timer and the pause counter. The oscillator is seen only
// through osc_tick (one pulse per crystal period) and osc_run.
module xo_ctrl_top
    import xo_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DELAY_W = 14,
    parameter int unsigned CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              osc_tick,
    output logic              osc_run
);

    logic               stable;
    logic               bad;
    logic [DELAY_W-1:0] delay;
    logic               x4;
    logic [CNT_W-1:0]   count;
    logic               cnt_wr;
    logic [CNT_W-1:0]   cnt_wdata;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    xo_apb_regs #(.ADDR_W(ADDR_W), .DELAY_W(DELAY_W), .CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .psel        (psel),
        .penable     (penable),
        .pwrite      (pwrite),
        .paddr       (paddr),
        .pwdata      (pwdata),
        .prdata      (prdata),
        .stable_i    (stable),
        .count_i     (count),
        .osc_run     (osc_run),
        .delay_o     (delay),
        .x4_o        (x4),
        .bad_o       (bad),
        .cnt_wr_o    (cnt_wr),
        .cnt_wdata_o (cnt_wdata)
    );

    xo_startup_timer #(.DELAY_W(DELAY_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (osc_run),
        .tick_i   (osc_tick),
        .delay_i  (delay),
        .x4_i     (x4),
        .stable_o (stable)
    );

    xo_pause_counter #(.CNT_W(CNT_W)) u_pause (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cnt_wr),
        .wdata_i  (cnt_wdata),
        .tick_i   (osc_tick),
        .stable_i (stable),
        .count_o  (count)
    );

endmodule

// File: rtl/xo_ctrl_checker.sv
// Property checker for xo_ctrl_top, attached by bind. Observes the APB
// port, the run request and the internal stable, error and counter state.
module xo_ctrl_checker
    import xo_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [31:0]       prdata,
    input logic              osc_tick,
    input logic              osc_run,
    input logic              stable,
    input logic              bad,
    input logic [CNT_W-1:0]  count
);

    logic acc_wr;
    logic acc_rd;
    logic cnt_wr;
    logic mapped;

    assign acc_wr = psel && penable && pwrite;
    assign acc_rd = psel && penable && !pwrite;
    assign cnt_wr = acc_wr && (paddr == ADDR_W'(OFF_COUNT));
    assign mapped = (paddr == ADDR_W'(OFF_CTRL)) || (paddr == ADDR_W'(OFF_STATUS))
                 || (paddr == ADDR_W'(OFF_PAUSE)) || (paddr == ADDR_W'(OFF_STARTUP))
                 || (paddr == ADDR_W'(OFF_COUNT));

    assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |=> !stable);

    assert_stable_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stable) |-> osc_run);

    assert_disable_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && paddr == ADDR_W'(OFF_CTRL) && pwdata[23:12] == KEY_OFF) |=> ##1 !osc_run);

    assert_pause_badcode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && paddr == ADDR_W'(OFF_PAUSE) && pwdata != KEY_PAUSE && pwdata != KEY_WAKE)
        |=> bad);

    assert_w1c_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && paddr == ADDR_W'(OFF_STATUS) && pwdata[ST_BAD_BIT]) |=> !bad);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bad && !(acc_wr && paddr == ADDR_W'(OFF_STATUS) && pwdata[ST_BAD_BIT])) |=> bad);

    assert_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && count == '0) |=> count == '0);

    assert_decrement_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && osc_tick && stable && count != '0) |=> count == CNT_W'($past(count) - 1'b1));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !(osc_tick && stable)) |=> $stable(count));

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !mapped) |-> prdata == 32'h0);

endmodule

bind xo_ctrl_top xo_ctrl_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xo_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .osc_tick (osc_tick),
    .osc_run  (osc_run),
    .stable   (stable),
    .bad      (bad),
    .count    (count)
);

// File: tb/tb_xo_ctrl_top.sv
// Scoreboard bench for xo_ctrl_top. Read tasks queue the expected value;
// a monitor at the falling edge pops the queue and compares it with prdata.
module tb_xo_ctrl_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned ADDR_W     = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              psel = 1'b0;
    logic              penable = 1'b0;
    logic              pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [31:0]       pwdata = '0;
    logic [31:0]       prdata;
    logic              pready;
    logic              pslverr;
    logic              osc_tick = 1'b0;
    logic              osc_run;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    xo_ctrl_top #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .osc_tick(osc_tick), .osc_run(osc_run)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read data phase against the queued expectation
    always @(negedge clk) begin
        if (psel && penable && !pwrite) begin
            check("R11 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
            if (sb_q.size() == 0) begin
                check("scoreboard underflow", 32'h1, 32'h0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, prdata, it.exp);
            end
        end
    end

    // All tasks enter and leave one time unit after a rising edge
    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic apb_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        idle(1);
        penable = 1'b1;
        idle(1);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_write_tick(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        osc_tick = 1'b1;
        apb_write(a, d);
        osc_tick = 1'b0;
    endtask

    task automatic apb_read(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        idle(1);
        penable = 1'b1;
        idle(1);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic ticks(input int n);
        osc_tick = 1'b1;
        idle(n);
        osc_tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Stimulus
    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset values
        check("R1 osc_run", {31'b0, osc_run}, 32'h0);
        apb_read(12'h00, 32'h00D1EAA0, "R1 ctrl");
        apb_read(12'h04, 32'h0,        "R1 status");
        apb_read(12'h08, 32'h77616B65, "R1 pause");
        apb_read(12'h0C, 32'h000000C4, "R1 startup");
        apb_read(12'h1C, 32'h0,        "R1 count");

        // R2 enable
        apb_write(12'h00, 32'h00FABAA0);
        idle(1);
        check("R2 osc_run on", {31'b0, osc_run}, 32'h1);
        apb_read(12'h00, 32'h00FABAA0, "R2 ctrl readback");
        apb_read(12'h04, 32'h00001000, "R2 status enabled, R8 not stable");

        // R7 startup field layout
        apb_write(12'h0C, 32'hFFFFFFFF);
        apb_read(12'h0C, 32'h00103FFF, "R7 startup mask");
        apb_write(12'h0C, 32'h00000001);
        apb_read(12'h0C, 32'h00000001, "R7 startup delay");

        // R8 threshold at 256 ticks
        ticks(255);
        apb_read(12'h04, 32'h00001000, "R8 one tick short");
        ticks(1);
        apb_read(12'h04, 32'h80001000, "R8 stable after 256");

        // R10 pause counter
        apb_write(12'h1C, 32'h00000105);
        apb_read(12'h1C, 32'h05, "R10 load");
        ticks(3);
        apb_read(12'h1C, 32'h02, "R10 decrement");
        ticks(10);
        apb_read(12'h1C, 32'h00, "R10 stops at zero");
        apb_write_tick(12'h1C, 32'h09);
        apb_read(12'h1C, 32'h09, "R10 write beats tick");

        // R5 / R9 pause
        apb_write(12'h08, 32'h636F6D61);
        idle(1);
        check("R5 osc_run paused", {31'b0, osc_run}, 32'h0);
        apb_read(12'h08, 32'h636F6D61, "R5 pause readback");
        apb_read(12'h04, 32'h00001000, "R9 stable cleared");
        ticks(4);
        apb_read(12'h1C, 32'h09, "R10 no decrement unstable");

        // R8 times four, R9 full restart on wake
        apb_write(12'h0C, 32'h00100001);
        apb_write(12'h08, 32'h77616B65);
        idle(1);
        check("R5 osc_run woken", {31'b0, osc_run}, 32'h1);
        ticks(1023);
        apb_read(12'h04, 32'h00001000, "R8 x4 one tick short");
        ticks(1);
        apb_read(12'h04, 32'h80001000, "R8 x4 stable after 1024");

        // R5 invalid pause code, R6 sticky and W1C
        apb_write(12'h08, 32'h12345678);
        apb_read(12'h08, 32'h77616B65, "R5 invalid selects wake");
        apb_read(12'h04, 32'h81001000, "R5 invalid sets error");
        apb_write(12'h04, 32'h00000000);
        apb_read(12'h04, 32'h81001000, "R6 zero write keeps flag");
        apb_write(12'h04, 32'h01000000);
        apb_read(12'h04, 32'h80001000, "R6 one write clears");

        // R4 range field
        apb_write(12'h00, 32'h00FABAA2);
        apb_read(12'h00, 32'h00FABAA0, "R4 range fixed");
        apb_read(12'h04, 32'h80001000, "R4 listed code no error");
        apb_write(12'h00, 32'h00FAB123);
        apb_read(12'h04, 32'h81001000, "R4 bad range sets error");
        apb_write(12'h04, 32'h01000000);

        // R2 disable, R9 stable lost
        apb_write(12'h00, 32'h00D1EAA0);
        idle(1);
        check("R2 osc_run off", {31'b0, osc_run}, 32'h0);
        apb_read(12'h04, 32'h00000000, "R2 R9 status after disable");
        apb_read(12'h00, 32'h00D1EAA0, "R2 ctrl disabled");

        // R3 invalid enable code
        apb_write(12'h00, 32'h00555AA0);
        idle(1);
        check("R3 osc_run on", {31'b0, osc_run}, 32'h1);
        apb_read(12'h00, 32'h00FABAA0, "R3 ctrl reads enable");
        apb_read(12'h04, 32'h01001000, "R3 error and enabled");

        // R11 unmapped offsets
        apb_read(12'h10, 32'h0, "R11 unmapped 0x10");
        apb_read(12'h20, 32'h0, "R11 unmapped 0x20");

        idle(2);
        check("scoreboard drained", sb_q.size(), 32'h0);
        finish_run();
    end

endmodule